// File: doc/BRIEF.md
# Triple Serial Converter Host Sequencer

This block is the host side of a three-channel simultaneous-sampling converter that talks over serial lines. It divides the system clock down to a continuous conversion clock. It asserts an active-low convert strobe when a conversion is requested. During each conversion it streams out a 13-bit setup word: an 8-bit DAC code, a 2-bit gain code and a 3-bit input select. In the same cycles it shifts in three 12-bit result streams in lockstep. When the last result bit arrives, the three results appear as two's-complement words, marked by a one-cycle valid pulse. The first two conversions after reset only prime the converter's setup register, so their results are withheld.

A sequencer state machine controls the block. Its three states are `ST_IDLE` (waiting), `ST_ARM` (strobe low, waiting for the first conversion-clock rise) and `ST_CONV` (counting the 14 clock pulses of a conversion). The transitions are as follows:
- IDLE→ARM is taken on a falling conversion-clock edge when a request is present or held.
- ARM→CONV is taken on the next rising edge, which is pulse 1.
- CONV→IDLE is taken on the falling edge after pulse 14 when no request is held.
- CONV→ARM is taken on that same edge when a request is held, which gives back-to-back conversions with no gap.

Top module: `tadc_host`

## Requirements
- R1: While reset is asserted, `cclk_o`, `sdo_o`, `busy_o` and `valid_o` are low and `conv_n_o` is high.
- R2: `cclk_o` is a continuous clock that stays in each level for exactly `HALF_DIV` system clock cycles.
- R3: A request drives `conv_n_o` low on a falling edge of `cclk_o`. The strobe stays low across exactly one rising edge (pulse 1) and is released on the following falling edge. Without a request, `conv_n_o` stays high and `busy_o` stays low.
- R4: A conversion spans 14 rising edges of `cclk_o`, counted from pulse 1. `busy_o` is high from the strobe assertion until the falling edge after pulse 14, and it is high whenever the strobe is low.
- R5: The setup word {dac_i[7:0], gain_i[1:0], sel_i[2:0]} is captured on the edge where the strobe goes low. It is sent MSB first, one bit per falling edge after pulses 1 to 13, so the device samples it on pulses 2 to 14. `sdo_o` is low whenever `busy_o` is low.
- R6: Each lane k of `din_i` is sampled on the falling edges after pulses 2 to 13, MSB first, in the same cycles for all three lanes.
- R7: Lane k of `res_o` (bits 12k+11..12k) holds the received word unchanged, in two's complement. 0x7FF is the most positive value, 0x800 the most negative and 0x000 mid-scale.
- R8: `valid_o` is high for exactly one system clock per delivered conversion, together with all three results.
- R9: Conversions 1 and 2 after reset produce no `valid_o`. Every later conversion produces one.
- R10: A request arriving while a conversion runs is held. The next strobe is asserted on the falling edge that ends pulse 14, so consecutive starts are 14 pulses apart. Several requests during one conversion yield a single extra conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Conversion request, one-cycle pulse |
| dac_i | input | DAC_W | DAC code for the setup word |
| gain_i | input | GAIN_W | Gain code for the setup word |
| sel_i | input | SEL_W | Input select code for the setup word |
| din_i | input | NCH | Serial result streams, one bit per lane |
| cclk_o | output | 1 | Conversion clock |
| conv_n_o | output | 1 | Convert strobe, active low |
| sdo_o | output | 1 | Serial setup word |
| res_o | output | NCH*RES_W | Results, lane k at bits 12k+11..12k |
| valid_o | output | 1 | Result valid pulse |
| busy_o | output | 1 | Conversion in progress |

## Verification
The bench models the device on the conversion clock: it reconstructs the setup word from `sdo_o` and feeds per-conversion random and directed result words. Several corner cases are covered, each catching a specific fault:
- **Warm-up.** A design that drops the warm-up gate would deliver the two priming results, and every later result would then pair with the wrong conversion.
- **Back-to-back chaining.** A held request is issued exactly 14 pulses later, which exposes an off-by-one gap. The bench also bursts requests into a single conversion, so a design that counted them would run an extra cycle.
- **Extreme codes.** The directed words 0x7FF, 0x800 and 0x000 catch bit-order or sign mistakes.
- **Setup-word alignment.** Reconstructing the word on pulses 2 to 14 catches a word shifted by one pulse.

// File: rtl/tadc_pkg.sv
package tadc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_CONV = 2'd2
    } seq_state_t;

endpackage

// File: rtl/tadc_clkgen.sv
module tadc_clkgen #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic cclk_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt_q;
    logic          wrap;

    assign wrap   = (cnt_q == CW'(HALF_DIV - 1));
    assign rise_o = wrap & ~cclk_o;
    assign fall_o = wrap & cclk_o;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            cclk_o <= 1'b0;
        end else if (wrap) begin
            cnt_q  <= '0;
            cclk_o <= ~cclk_o;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // R2: level held between divider wraps
    p_level_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(cclk_o));

    // R2: a rise event leads to a high clock
    p_rise_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> cclk_o);

endmodule

// File: rtl/tadc_seq.sv
module tadc_seq
    import tadc_pkg::*;
#(
    parameter int PULSES = 14,
    parameter int CFG_W  = 13,
    parameter int RES_W  = 12,
    parameter int WARMUP = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic rise_i,
    input  logic fall_i,
    output logic conv_n_o,
    output logic busy_o,
    output logic valid_o,
    output logic load_o,
    output logic shift_o,
    output logic cap_o,
    output logic last_o,
    output logic end_o
);
    localparam int PW = $clog2(PULSES + 1);
    localparam int WW = $clog2(WARMUP + 2);

    seq_state_t    state_q, state_d;
    logic [PW-1:0] pulse_q;
    logic          pend_q;
    logic [WW-1:0] warm_q;
    logic          in_conv, cyc_end, go_arm, req;

    assign in_conv = (state_q == ST_CONV);
    assign cyc_end = in_conv && fall_i && (pulse_q == PW'(PULSES));
    assign req     = pend_q || start_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (fall_i && req) state_d = ST_ARM;
            ST_ARM:  if (rise_i)        state_d = ST_CONV;
            ST_CONV: if (cyc_end)       state_d = req ? ST_ARM : ST_IDLE;
            default:                    state_d = ST_IDLE;
        endcase
    end

    assign go_arm  = (state_d == ST_ARM) && (state_q != ST_ARM);
    assign load_o  = go_arm;
    assign shift_o = in_conv && fall_i && (pulse_q >= PW'(1)) && (pulse_q <= PW'(CFG_W));
    assign cap_o   = in_conv && fall_i && (pulse_q >= PW'(2)) && (pulse_q <= PW'(RES_W + 1));
    assign last_o  = in_conv && fall_i && (pulse_q == PW'(RES_W + 1));
    assign end_o   = cyc_end;

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pulse_q <= '0;
            pend_q  <= 1'b0;
            warm_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_ARM && rise_i)
                pulse_q <= PW'(1);
            else if (in_conv && rise_i)
                pulse_q <= pulse_q + 1'b1;
            if (go_arm)
                pend_q <= 1'b0;
            else if (start_i)
                pend_q <= 1'b1;
            if (cyc_end && warm_q < WW'(WARMUP))
                warm_q <= warm_q + 1'b1;
        end
    end

    // output process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_n_o <= 1'b1;
            busy_o   <= 1'b0;
            valid_o  <= 1'b0;
        end else begin
            if (go_arm)
                conv_n_o <= 1'b0;
            else if (in_conv && fall_i && pulse_q == PW'(1))
                conv_n_o <= 1'b1;
            busy_o  <= (state_d != ST_IDLE);
            valid_o <= last_o && (warm_q >= WW'(WARMUP));
        end
    end

    // R4: strobe never low outside a busy conversion
    p_strobe_in_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_n_o |-> busy_o);

    // R4: pulse counter stays within one conversion
    p_pulse_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q <= PW'(PULSES));

    // R8: valid is a single-cycle pulse
    p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R9: no result before warm-up conversions are done
    p_valid_warm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (warm_q >= WW'(WARMUP)));

    // R10: a held request chains straight into the next conversion
    p_chain_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_end && pend_q) |=> (state_q == ST_ARM));

endmodule

// File: rtl/tadc_shift.sv
module tadc_shift #(
    parameter int CFG_W = 13,
    parameter int RES_W = 12,
    parameter int NCH   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic                 shift_i,
    input  logic                 cap_i,
    input  logic                 last_i,
    input  logic                 end_i,
    input  logic [CFG_W-1:0]     cfg_i,
    input  logic [NCH-1:0]       din_i,
    output logic                 sdo_o,
    output logic [NCH*RES_W-1:0] res_o
);
    logic [CFG_W-1:0] cfg_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            sdo_o <= 1'b0;
        end else if (load_i) begin
            cfg_q <= cfg_i;
            sdo_o <= 1'b0;
        end else if (shift_i) begin
            sdo_o <= cfg_q[CFG_W-1];
            cfg_q <= {cfg_q[CFG_W-2:0], 1'b0};
        end else if (end_i) begin
            sdo_o <= 1'b0;
        end
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_lane
        logic [RES_W-1:0] sr_q;
        logic [RES_W-1:0] res_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sr_q  <= '0;
                res_q <= '0;
            end else begin
                if (cap_i)
                    sr_q <= {sr_q[RES_W-2:0], din_i[ch]};
                if (last_i)
                    res_q <= {sr_q[RES_W-2:0], din_i[ch]};
            end
        end

        assign res_o[ch*RES_W +: RES_W] = res_q;
    end

    // R5: serial line returns low at the end of each conversion
    p_sdo_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        end_i && !load_i |=> !sdo_o);

    // R6: last capture is always a capture edge
    p_last_is_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        last_i |-> cap_i);

endmodule

// File: rtl/tadc_host.sv
module tadc_host #(
    parameter int HALF_DIV = 4,
    parameter int DAC_W    = 8,
    parameter int GAIN_W   = 2,
    parameter int SEL_W    = 3,
    parameter int RES_W    = 12,
    parameter int NCH      = 3,
    parameter int WARMUP   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [DAC_W-1:0]     dac_i,
    input  logic [GAIN_W-1:0]    gain_i,
    input  logic [SEL_W-1:0]     sel_i,
    input  logic [NCH-1:0]       din_i,
    output logic                 cclk_o,
    output logic                 conv_n_o,
    output logic                 sdo_o,
    output logic [NCH*RES_W-1:0] res_o,
    output logic                 valid_o,
    output logic                 busy_o
);
    localparam int CFG_W  = DAC_W + GAIN_W + SEL_W;
    localparam int PULSES = CFG_W + 1;

    logic rise, fall, load, shift, cap, last, cyc_end;

    tadc_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
        .clk    (clk),
        .rst_n  (rst_n),
        .cclk_o (cclk_o),
        .rise_o (rise),
        .fall_o (fall)
    );

    tadc_seq #(
        .PULSES (PULSES),
        .CFG_W  (CFG_W),
        .RES_W  (RES_W),
        .WARMUP (WARMUP)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .rise_i   (rise),
        .fall_i   (fall),
        .conv_n_o (conv_n_o),
        .busy_o   (busy_o),
        .valid_o  (valid_o),
        .load_o   (load),
        .shift_o  (shift),
        .cap_o    (cap),
        .last_o   (last),
        .end_o    (cyc_end)
    );

    tadc_shift #(
        .CFG_W (CFG_W),
        .RES_W (RES_W),
        .NCH   (NCH)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .shift_i (shift),
        .cap_i   (cap),
        .last_i  (last),
        .end_i   (cyc_end),
        .cfg_i   ({dac_i, gain_i, sel_i}),
        .din_i   (din_i),
        .sdo_o   (sdo_o),
        .res_o   (res_o)
    );

    // R3: strobe asserted only as the conversion clock falls
    p_strobe_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(conv_n_o) |-> $fell(cclk_o));

    // R5: serial line idle low outside conversions
    p_sdo_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !sdo_o);

endmodule

// File: tb/test_tadc_host.sv
module test_tadc_host;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_DIV   = 4;
    localparam int RES_W      = 12;
    localparam int NCH        = 3;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start = 1'b0;
    logic [7:0]           dac = '0;
    logic [1:0]           gain = '0;
    logic [2:0]           sel = '0;
    logic [NCH-1:0]       din = '0;
    logic                 cclk, conv_n, sdo, valid, busy;
    logic [NCH*RES_W-1:0] res;

    int n_chk = 0;
    int n_bad = 0;

    tadc_host #(.HALF_DIV(HALF_DIV)) i_tadc_host (
        .clk(clk), .rst_n(rst_n), .start_i(start), .dac_i(dac), .gain_i(gain),
        .sel_i(sel), .din_i(din), .cclk_o(cclk), .conv_n_o(conv_n), .sdo_o(sdo),
        .res_o(res), .valid_o(valid), .busy_o(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // device model state
    logic [11:0] dev_val [0:63][0:2];
    logic [12:0] exp_cfg [0:63];
    int          start_rise [0:63];
    int          conv_idx = 0;
    int          rises = 0;
    int          pulse = 0;
    bit          active = 0;
    logic [12:0] sh = '0;
    int          n_valid = 0;
    logic        prev_valid = 1'b0;

    function automatic logic [12:0] cfg_word(input logic [7:0] d, input logic [1:0] g, input logic [2:0] s);
        return {d, g, s};
    endfunction

    always @(negedge conv_n) begin
        if (rst_n && conv_idx < 63) exp_cfg[conv_idx + 1] = cfg_word(dac, gain, sel);
    end

    always @(posedge cclk) begin
        #1;
        rises++;
        if (!active && !conv_n) begin
            active = 1;
            pulse = 1;
            conv_idx++;
            start_rise[conv_idx] = rises;
            sh = '0;
        end else if (active) begin
            pulse++;
            if (pulse == 2) check(conv_n == 1'b1, "R3 strobe released after pulse 1", conv_n, 1);
            if (pulse >= 2 && pulse <= 14) sh = {sh[11:0], sdo};
            if (pulse >= 2 && pulse <= 13)
                for (int c = 0; c < NCH; c++) din[c] = dev_val[conv_idx][c][13 - pulse];
            if (pulse == 14) begin
                check(busy == 1'b1, "R4 busy through pulse 14", busy, 1);
                check(sh == exp_cfg[conv_idx], "R5 setup word", sh, exp_cfg[conv_idx]);
                active = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_valid && valid) check(0, "R8 valid longer than one cycle", 1, 0);
            if (valid) begin
                n_valid++;
                for (int c = 0; c < NCH; c++)
                    check(res[c*RES_W +: RES_W] == dev_val[n_valid + 2][c],
                          "R6 R7 lane result", res[c*RES_W +: RES_W], dev_val[n_valid + 2][c]);
            end
            prev_valid = valid;
        end
    end

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic rand_cfg();
        dac = 8'($urandom); gain = 2'($urandom); sel = 3'($urandom);
    endtask

    task automatic single_conv();
        @(negedge clk); rand_cfg();
        pulse_start();
        while (!busy) @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
        $finish;
    end

    initial begin
        int cnt;
        bit quiet;
        void'($urandom(32'd1357));
        for (int i = 0; i < 64; i++)
            for (int c = 0; c < NCH; c++) dev_val[i][c] = 12'($urandom);
        dev_val[3][0] = 12'h7FF; dev_val[3][1] = 12'h800; dev_val[3][2] = 12'h000;
        dev_val[4][0] = 12'h800; dev_val[4][1] = 12'h000; dev_val[4][2] = 12'h7FF;
        dev_val[5][0] = 12'h001; dev_val[5][1] = 12'hFFF; dev_val[5][2] = 12'h800;

        repeat (4) @(negedge clk);
        // R1 reset state
        check(cclk == 0 && sdo == 0 && busy == 0 && valid == 0, "R1 reset lows", {cclk, sdo, busy, valid}, 0);
        check(conv_n == 1, "R1 strobe high in reset", conv_n, 1);
        @(negedge clk); rst_n = 1'b1;

        // R2 half-period measurement
        for (int k = 0; k < 2; k++) begin
            @(posedge cclk);
            cnt = 0;
            while (cclk) begin @(posedge clk); cnt++; #1; end
            check(cnt == HALF_DIV, "R2 high phase length", cnt, HALF_DIV);
            cnt = 0;
            while (!cclk) begin @(posedge clk); cnt++; #1; end
            check(cnt == HALF_DIV, "R2 low phase length", cnt, HALF_DIV);
        end

        // R3 no request, no conversion
        quiet = 1;
        repeat (60) begin @(negedge clk); if (!conv_n || busy) quiet = 0; end
        check(quiet, "R3 idle without request", quiet, 1);

        // R9 warm-up
        single_conv();
        single_conv();
        repeat (HALF_DIV * 4) @(negedge clk);
        check(n_valid == 0, "R9 no valid during warm-up", n_valid, 0);

        // R7 directed extreme codes (conversions 3..5)
        for (int k = 0; k < 3; k++) single_conv();
        repeat (HALF_DIV * 4) @(negedge clk);
        check(n_valid == 3, "R9 valid from third conversion", n_valid, 3);

        // R10 back-to-back chain, conversions 6..12
        for (int i = 6; i <= 12; i++) begin
            @(negedge clk); rand_cfg();
            pulse_start();
            if (i == 9) begin repeat (3) @(negedge clk); pulse_start(); end
            while (conv_idx < i) @(negedge clk);
            repeat (2 * HALF_DIV) @(negedge clk);
        end
        while (busy) @(negedge clk);
        repeat (40 * HALF_DIV) @(negedge clk);
        check(conv_idx == 12, "R10 repeated requests collapse", conv_idx, 12);
        for (int i = 6; i < 12; i++)
            check(start_rise[i + 1] - start_rise[i] == 14, "R10 R4 14-pulse spacing",
                  start_rise[i + 1] - start_rise[i], 14);

        // random singles with gaps
        for (int i = 0; i < 10; i++) begin
            repeat (1 + ($urandom % 30)) @(negedge clk);
            single_conv();
        end
        repeat (HALF_DIV * 4) @(negedge clk);
        check(n_valid == conv_idx - 2, "R8 R9 one valid per delivered conversion", n_valid, conv_idx - 2);
        check(busy == 0 && sdo == 0, "R5 idle serial line low", {busy, sdo}, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule